// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a parallel input port and signals the host through an active-low, open-drain interrupt line whenever the port moves away from a stored reference image. The reference image is captured right after reset and again every time the host services the port. Any bit that rises or falls relative to that image pulls the line low. The line is released again when the pins go back to the stored image, or when the host reads or writes the port.

The bus controller beside it supplies two single-cycle strobes. One marks the acknowledge bit of a read, taken at the rising clock edge of that bit. The other marks the acknowledge bit of a write, taken at the falling clock edge of that bit. The controller also supplies a select flag that is high only while the current transfer is addressed to this device. A strobe that comes while select is low has no effect, so traffic to other devices on the same bus leaves the interrupt alone.

When a strobe is accepted, the reference image is reloaded from the pins as they are in that cycle. A pin change that lands in the same cycle as the strobe is therefore absorbed into the new image and never raises the line. The pin inputs are assumed to be synchronised to `clk_i` already.

Top module: `port_change_irq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `irq_pull_o` is 0 (line released). The reference image is loaded from the pins in that first cycle, so pins held unchanged through and after reset never pull the line.
- R2: When any bit of `pins_i` differs from the reference image, whether it rose or fell, `irq_pull_o` goes to 1 (drive the line low) one clock after the difference appears. It stays at 1 for as long as the difference lasts and no clear is accepted.
- R3: When `pins_i` returns to equal the reference image, `irq_pull_o` returns to 0 one clock later, with no host access.
- R4: A read-acknowledge pulse (`rd_ack_i`=1) with `sel_i`=1 sets `irq_pull_o` to 0 on the next clock.
- R5: A write-acknowledge pulse (`wr_ack_i`=1) with `sel_i`=1 sets `irq_pull_o` to 0 on the next clock.
- R6: `rd_ack_i` or `wr_ack_i` pulses with `sel_i`=0 change neither `irq_pull_o` nor the reference image.
- R7: An accepted clear reloads the reference image from the `pins_i` value of that cycle. Pins that stay unchanged afterwards keep the line released. Any later change against the new image pulls the line again, including a return to the old value.
- R8: A pin change that arrives in the same cycle as an accepted clear becomes part of the new image and does not pull the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | WIDTH (16) | Synchronised port pin levels |
| sel_i | input | 1 | Current transfer is addressed to this device |
| rd_ack_i | input | 1 | One-cycle pulse at the read acknowledge bit (rising clock edge) |
| wr_ack_i | input | 1 | One-cycle pulse at the write acknowledge bit (falling clock edge) |
| irq_pull_o | output | 1 | 1 = drive the interrupt line low, 0 = release it |

## Verification
Embedded properties check, on every cycle, the relation between a mismatch against the image and the line one clock later. They also check that any accepted clear releases the line, that the image holds still between clears, and that a clear loads the image from the pins of that cycle. Other properties are left to the bench's scenarios. These are that unselected strobes are really ignored, that a change in the clear cycle is lost, that a return to the old value after a reload is seen as a new change, and that the reset image equals the pins. The bench shows them by running concrete pin and strobe sequences and comparing the line with values predicted in advance.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;

  // Which host access caused a clear in the current cycle
  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_READ  = 2'b01,
    CLR_WRITE = 2'b10,
    CLR_BOTH  = 2'b11
  } clr_src_e;

  function automatic clr_src_e clr_src_of(input logic rd, input logic wr);
    return clr_src_e'({wr, rd});
  endfunction

endpackage

// File: rtl/port_irq_clr.sv
module port_irq_clr
  import port_irq_pkg::*;
(
  input  logic     sel_i,
  input  logic     rd_ack_i,
  input  logic     wr_ack_i,
  output logic     clear_o,
  output clr_src_e cause_o
);

  logic rd_hit;
  logic wr_hit;

  // only strobes of transfers addressed here count
  assign rd_hit  = sel_i & rd_ack_i;
  assign wr_hit  = sel_i & wr_ack_i;
  assign cause_o = clr_src_of(rd_hit, wr_hit);
  assign clear_o = (cause_o != CLR_NONE);

endmodule

// File: rtl/port_irq_diff.sv
module port_irq_diff #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] pins_i,
  input  logic [WIDTH-1:0] ref_i,
  output logic             diff_o
);

  logic [WIDTH-1:0] bit_diff;

  // per-bit edge detect against the reference image, both polarities
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign bit_diff[b] = pins_i[b] ^ ref_i[b];
  end

  assign diff_o = |bit_diff;

endmodule

// File: rtl/port_irq_snap.sv
module port_irq_snap #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             load_i,
  output logic [WIDTH-1:0] ref_o,
  output logic             primed_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o    <= '0;
      primed_o <= 1'b0;
    end else if (!primed_o) begin
      ref_o    <= pins_i;
      primed_o <= 1'b1;
    end else if (load_i) begin
      ref_o    <= pins_i;
    end
  end

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import port_irq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             sel_i,
  input  logic             rd_ack_i,
  input  logic             wr_ack_i,
  output logic             irq_pull_o
);

  logic             clear;
  clr_src_e         cause;
  logic [WIDTH-1:0] snap;
  logic             primed;
  logic             mismatch;
  logic             irq_q;

  port_irq_clr u_clr (
    .sel_i    (sel_i),
    .rd_ack_i (rd_ack_i),
    .wr_ack_i (wr_ack_i),
    .clear_o  (clear),
    .cause_o  (cause)
  );

  port_irq_snap #(.WIDTH(WIDTH)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (pins_i),
    .load_i   (clear),
    .ref_o    (snap),
    .primed_o (primed)
  );

  port_irq_diff #(.WIDTH(WIDTH)) u_diff (
    .pins_i (pins_i),
    .ref_i  (snap),
    .diff_o (mismatch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               irq_q <= 1'b0;
    else if (!primed || clear) irq_q <= 1'b0;
    else                       irq_q <= mismatch;
  end

  assign irq_pull_o = irq_q;

  // R1
  reset_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed |-> !irq_pull_o);

  // R2
  change_pulls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !clear && mismatch) |=> irq_pull_o);

  // R3
  match_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !mismatch) |=> !irq_pull_o);

  // R4 R5
  access_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause != CLR_NONE) |=> !irq_pull_o);

  // R6
  image_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !clear) |=> $stable(snap));

  // R7
  image_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && clear) |=> (snap == $past(pins_i)));

endmodule

// File: tb/port_change_irq_tb.sv
module port_change_irq_tb;

  localparam int W = 16;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = 16'hA5C3;
  logic         sel = 1'b0;
  logic         rd = 1'b0;
  logic         wr = 1'b0;
  logic         irq;

  int    n_run  = 0;
  int    n_fail = 0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  port_change_irq #(.WIDTH(W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pins_i     (pins),
    .sel_i      (sel),
    .rd_ack_i   (rd),
    .wr_ack_i   (wr),
    .irq_pull_o (irq)
  );

  // monitor: each pushed item is due right after the following rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (irq !== it.exp) begin
        n_fail++;
        $display("FAIL %s: irq_pull_o=%b expected %b", it.tag, irq, it.exp);
      end
    end
  end

  // driver: applies inputs for one cycle and queues the expected line level
  task automatic step(input logic [W-1:0] p, input logic r, input logic w,
                      input logic s, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    pins = p; rd = r; wr = w; sel = s;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: line released during reset
    n_run++;
    if (irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: irq_pull_o=%b during reset expected 0", irq);
    end
    rst_n = 1'b1;
    step(16'hA5C3, 0, 0, 0, 1'b0, "R1 first cycle");
    step(16'hA5C3, 0, 0, 0, 1'b0, "R1 image equals pins");
    // R2 falling bit 0
    step(16'hA5C2, 0, 0, 0, 1'b1, "R2 bit0 fall");
    step(16'hA5C2, 0, 0, 0, 1'b1, "R2 held");
    // R3 return to image
    step(16'hA5C3, 0, 0, 0, 1'b0, "R3 return");
    // R2 falling bit 15
    step(16'h25C3, 0, 0, 0, 1'b1, "R2 bit15 fall");
    step(16'h25C3, 0, 0, 0, 1'b1, "R2 held");
    // R4 read clears
    step(16'h25C3, 1, 0, 1, 1'b0, "R4 read ack");
    step(16'h25C3, 0, 0, 0, 1'b0, "R7 reloaded image");
    // R7 old value is a new change
    step(16'hA5C3, 0, 0, 0, 1'b1, "R7 change detected again");
    // R6 unselected strobes ignored
    step(16'hA5C3, 0, 1, 0, 1'b1, "R6 write unselected");
    step(16'hA5C3, 1, 0, 0, 1'b1, "R6 read unselected");
    step(16'hA5C3, 0, 0, 0, 1'b1, "R6 image untouched");
    // R5 write clears
    step(16'hA5C3, 0, 1, 1, 1'b0, "R5 write ack");
    step(16'hA5C3, 0, 0, 0, 1'b0, "R7 stays released");
    // R8 change coinciding with clear is absorbed
    step(16'hA4C3, 0, 1, 1, 1'b0, "R8 change in clear cycle");
    step(16'hA4C3, 0, 0, 0, 1'b0, "R8 change lost");
    step(16'hA5C3, 0, 0, 0, 1'b1, "R7 against new image");
    step(16'hFFFF, 0, 0, 0, 1'b1, "R2 many bits");
    step(16'hA4C3, 0, 0, 0, 1'b0, "R3 back to image");
    step(16'hA4C7, 0, 0, 0, 1'b1, "R2 bit2 rise");
    step(16'hA4C7, 1, 1, 1, 1'b0, "R4 R5 both strobes");
    step(16'hA4C7, 0, 0, 0, 1'b0, "R7 after both");
    step(16'hA4C7, 0, 0, 0, 1'b0, "R7 settle");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule